// File: doc/BRIEF.md
# Four-phase handshake duplicator

This block is a control component for four-phase request/acknowledge signalling. It has one passive port, where an upstream partner raises a request and waits for an acknowledge. It also has one active port, where the block itself raises requests towards a downstream partner. For every complete handshake on the passive side, the block runs exactly two complete handshakes on the active side.

In the first sub-handshake, the block raises the downstream request and waits for the acknowledge. It then drops the request and waits for the acknowledge to return to zero. In the second sub-handshake, it raises the request again. Once that second acknowledge arrives, the block acknowledges upstream. It holds the second downstream request high until the upstream request falls. It releases its own upstream acknowledge only after the downstream acknowledge has gone low again.

The block is a clocked state machine that samples the request and acknowledge levels on each rising edge. The top module is a parameterised chain of such cells. With STAGES cells in series, the far port sees 2^STAGES handshakes per near handshake, so handshake frequency is divided by a power of two.

Top module: `hs_dup_chain`

## Requirements
- R1: While rst_ni is low, out_req_o and in_ack_o are low, and each cell's sub-handshake flag is cleared. Reset is asynchronous.
- R2: Each cell performs exactly two complete handshakes on its active side per complete handshake on its passive side. With STAGES cells, out_req_o/out_ack_i complete 2^STAGES handshakes per in_req_i/in_ack_o handshake.
- R3: in_ack_o rises only after out_ack_i has risen for the last (2^STAGES-th) downstream handshake belonging to the current upstream handshake.
- R4: After in_ack_o has risen, out_req_o stays high for as long as in_req_i stays high. The last downstream request returns to zero only after the upstream request has fallen.
- R5: in_ack_o falls only after out_ack_i has been sampled low.
- R6: out_req_o rises only when out_ack_i was low on the previous clock edge, so the downstream handshake always returns to zero.
- R7: From the idle state with in_req_i held low, out_req_o and in_ack_o stay low indefinitely.
- R8: From idle, out_req_o rises exactly STAGES rising clock edges after in_req_i is first sampled high (one register per cell).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_req_i | input | 1 | Request on the passive (upstream) port |
| in_ack_o | output | 1 | Acknowledge on the passive port |
| out_req_o | output | 1 | Request on the active (downstream) port |
| out_ack_i | input | 1 | Acknowledge on the active port |

## Verification
The bench chains two cells behind a responder whose acknowledge delays are random. It sweeps the gap between the upstream acknowledge and the release of the upstream request from zero to three cycles, and counts far-side acknowledges per near handshake; a cell that merged or skipped its second sub-handshake would report two or three instead of four. A zero-gap release tests the overlap of the last downstream release with the upstream release: a design that dropped the request early, or dropped the acknowledge while the far acknowledge was still high, is caught by the hold and release monitors. A reset in the middle of a handshake and a long idle stretch with the request low expose a design that is not initialisable or that starts a handshake spontaneously.

// File: rtl/hs_dup_pkg.sv
package hs_dup_pkg;
  // Per-cell state: registered outputs plus the sub-handshake flag
  typedef struct packed {
    logic out_req;
    logic in_ack;
    logic second;
  } hs_dup_state_t;
endpackage

// File: rtl/hs_dup_next.sv
module hs_dup_next
  import hs_dup_pkg::*;
(
  input  hs_dup_state_t cur_i,
  input  logic          in_req_i,
  input  logic          out_ack_i,
  output hs_dup_state_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (!cur_i.out_req && !cur_i.in_ack) begin
      // start first (needs upstream req) or second sub-handshake
      if (!out_ack_i && (cur_i.second || in_req_i)) nxt_o.out_req = 1'b1;
    end else if (cur_i.out_req && !cur_i.in_ack) begin
      if (out_ack_i) begin
        if (!cur_i.second) begin
          nxt_o.out_req = 1'b0;
          nxt_o.second  = 1'b1;
        end else begin
          nxt_o.in_ack = 1'b1;
        end
      end
    end else if (cur_i.out_req && cur_i.in_ack) begin
      if (!in_req_i) nxt_o.out_req = 1'b0;
    end else begin
      if (!out_ack_i) begin
        nxt_o.in_ack = 1'b0;
        nxt_o.second = 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_dup_cell.sv
module hs_dup_cell
  import hs_dup_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_req_i,
  output logic in_ack_o,
  output logic out_req_o,
  input  logic out_ack_i
);
  hs_dup_state_t st_q, st_d;
  logic          second_q;

  hs_dup_next u_next (
    .cur_i    (st_q),
    .in_req_i (in_req_i),
    .out_ack_i(out_ack_i),
    .nxt_o    (st_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign out_req_o = st_q.out_req;
  assign in_ack_o  = st_q.in_ack;
  assign second_q  = st_q.second;

  // R1
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_req_o && !in_ack_o && !second_q));

  // R2: second sub-handshake begins only as the first one releases
  p_second_on_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(second_q) |-> ($fell(out_req_o) && $past(out_ack_i)));

  p_ack_after_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> $past(out_ack_i && out_req_o && second_q));

  p_hold_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ack_o && in_req_i) |-> out_req_o);

  p_ack_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ack_o) |-> $past(!out_ack_i));

  p_rtz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_req_o) |-> $past(!out_ack_i));

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_req_o && !in_ack_o && !second_q && !in_req_i) |=> !out_req_o);
endmodule

// File: rtl/hs_dup_chain.sv
module hs_dup_chain #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_req_i,
  output logic in_ack_o,
  output logic out_req_o,
  input  logic out_ack_i
);
  localparam int LINKS = STAGES + 1;

  logic [LINKS-1:0] req_w;
  logic [LINKS-1:0] ack_w;

  assign req_w[0]      = in_req_i;
  assign in_ack_o      = ack_w[0];
  assign out_req_o     = req_w[STAGES];
  assign ack_w[STAGES] = out_ack_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    hs_dup_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .in_req_i (req_w[s]),
      .in_ack_o (ack_w[s]),
      .out_req_o(req_w[s+1]),
      .out_ack_i(ack_w[s+1])
    );
  end
endmodule

// File: tb/tb_hs_dup_chain.sv
module tb_hs_dup_chain;
  localparam int STAGES  = 2;
  localparam int FAR_PER = 1 << STAGES;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic in_req_i = 1'b0;
  logic out_ack_i = 1'b0;
  logic in_ack_o, out_req_o;

  int n_tests = 0, n_fail = 0;
  int far_rises = 0, hs_base = 0, cycles = 0;
  int r4_viol = 0, r5_viol = 0, r6_viol = 0;
  int resp_dly = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hs_dup_chain #(.STAGES(STAGES)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_req_i(in_req_i), .in_ack_o(in_ack_o),
    .out_req_o(out_req_o), .out_ack_i(out_ack_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Far-side responder with random delays
  initial begin
    forever begin
      @(negedge clk);
      if (out_req_o !== out_ack_i) begin
        if (resp_dly == 0) begin
          if (out_req_o && !out_ack_i) far_rises++;
          out_ack_i = out_req_o;
          resp_dly = $urandom_range(0, 3);
        end else resp_dly--;
      end
    end
  end

  // Protocol monitor, sampled away from the clock edges
  logic p_req, p_ack, p_oreq, p_oack, p_rst;
  initial begin
    p_req = 0; p_ack = 0; p_oreq = 0; p_oack = 0; p_rst = 0;
    forever begin
      @(negedge clk); #2;
      if (rst_ni && p_rst) begin
        if (!p_ack && in_ack_o) begin
          check(far_rises - hs_base == FAR_PER, "R3", far_rises - hs_base, FAR_PER);
          if (!out_req_o) r4_viol++;
        end
        if (p_ack && in_ack_o && in_req_i && !out_req_o) r4_viol++;
        if (p_ack && !in_ack_o && p_oack) r5_viol++;
        if (!p_oreq && out_req_o && p_oack) r6_viol++;
      end
      p_req = in_req_i; p_ack = in_ack_o; p_oreq = out_req_o;
      p_oack = out_ack_i; p_rst = rst_ni;
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        check(0, "watchdog", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic wait_ack(input logic lvl, input string req);
    int t = 0;
    while (in_ack_o !== lvl && t < 500) begin @(negedge clk); t++; end
    check(in_ack_o === lvl, req, int'(in_ack_o), int'(lvl));
  endtask

  // One near handshake; R2 checks the far count once it has completed
  task automatic near_hs(input int gap);
    @(negedge clk);
    hs_base = far_rises;
    in_req_i = 1'b1;
    wait_ack(1'b1, "R3 ack rise");
    repeat (gap) @(negedge clk);
    in_req_i = 1'b0;
    wait_ack(1'b0, "R5 ack fall");
    check(far_rises - hs_base == FAR_PER, "R2", far_rises - hs_base, FAR_PER);
    check(out_req_o == 1'b0 && out_ack_i == 1'b0, "R2 far idle", int'(out_req_o), 0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(out_req_o == 0 && in_ack_o == 0, "R1 reset", int'({out_req_o, in_ack_o}), 0);
    rst_ni = 1'b1;

    // R7: request held low from idle
    repeat (30) begin
      @(negedge clk);
      if (out_req_o || in_ack_o) r6_viol += 0;
    end
    check(out_req_o == 0 && in_ack_o == 0, "R7 idle quiet", int'({out_req_o, in_ack_o}), 0);

    // R8: latency of one edge per stage
    @(negedge clk);
    hs_base = far_rises;
    in_req_i = 1'b1;
    for (int e = 1; e <= STAGES; e++) begin
      @(negedge clk);
      check(out_req_o == (e == STAGES), "R8 latency", int'(out_req_o), int'(e == STAGES));
    end
    wait_ack(1'b1, "R3 ack rise");
    in_req_i = 1'b0;
    wait_ack(1'b0, "R5 ack fall");
    check(far_rises - hs_base == FAR_PER, "R2", far_rises - hs_base, FAR_PER);

    // Sweep of release gaps
    for (int gap = 0; gap < 4; gap++)
      for (int k = 0; k < 10; k++) near_hs(gap);

    // R1: asynchronous reset in mid-handshake
    @(negedge clk);
    in_req_i = 1'b1;
    begin
      int t = 0;
      while (!out_req_o && t < 50) begin @(negedge clk); t++; end
    end
    rst_ni = 1'b0;
    #1;
    check(out_req_o == 0 && in_ack_o == 0, "R1 async reset", int'({out_req_o, in_ack_o}), 0);
    in_req_i = 1'b0;
    repeat (10) @(negedge clk);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    check(out_req_o == 0 && in_ack_o == 0, "R7 after reset", int'({out_req_o, in_ack_o}), 0);

    for (int k = 0; k < 8; k++) near_hs(k % 3);

    check(r4_viol == 0, "R4 hold last request", r4_viol, 0);
    check(r5_viol == 0, "R5 ack release order", r5_viol, 0);
    check(r6_viol == 0, "R6 return to zero", r6_viol, 0);
    done = 1;
    finish_run();
  end
endmodule